// File: doc/BRIEF.md
# Embedded Flash Command Controller

This block sits between a small register bus and an on-chip flash array made of 512-byte pages of 16-bit halfwords. Software loads an address and a data word into registers, sets a write-enable bit in the mode register, and then writes a command code to start a halfword program, a page erase or a whole-array erase. A status register reports whether the controller is busy and whether the last command passed or failed. A command that is refused because writes are not enabled, or whose code is unknown, leaves both result bits clear, which tells it apart from a failure.

The array is held in ordinary synchronous storage inside the block. Each operation lasts a parameterised number of cycles, with a program about fifty times shorter than a page erase and a whole-array erase about seventy times longer again. The address register holds a byte offset from the start of the array. In the target chip the array is mapped at 0x80000 and has 124 usable pages. A read command copies one halfword into the data register, so the array contents can be checked over the same bus.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, the status, mode, data and address registers all read as zero.
- R2: The bus index is bus_addr[4:2]: 0 status, 1 mode, 2 command, 3 data, 4 address, 5 to 7 reserved. Mode, data and address read back what was last written. The command and reserved registers read as zero and ignore writes.
- R3: An accepted command makes status bit 2 (busy) read 1 from the next cycle on. Busy lasts the larger of the operation latency and the number of halfwords swept. The latency is 1 for a read, PROG_CYC for a program, PAGE_CYC for a page erase and MASS_CYC for a mass erase. Busy then drops and status bit 0 (pass) is set.
- R4: Code 0x02 replaces the halfword at address[15:1] with its old value ANDed with the data register. Address bit 0 is ignored.
- R5: Code 0x05 sets every halfword of the 512-byte page that holds the address to 0xFFFF and leaves every other page unchanged.
- R6: Code 0x06 erases the whole array to 0xFFFF only if the data register holds 0x3CFF and the address register holds 0xFFC3. Otherwise the fail bit is set, busy stays 0, and the array is unchanged.
- R7: While mode bit 3 is 0, codes 0x02, 0x05 and 0x06 are dropped. They change nothing in the array, busy stays 0, and status bits 0 and 1 are cleared.
- R8: For codes 0x01, 0x02 and 0x05, an address at or beyond NUM_PAGES*512 sets status bit 1 (fail), busy stays 0, and the array is unchanged.
- R9: Any other code leaves the array unchanged, busy stays 0, and status bits 0 and 1 are cleared.
- R10: While busy, every bus write is ignored, including command writes, and the status result bits do not change.
- R11: Code 0x01 loads the data register with the addressed halfword and ends with pass.
- R12: Status reads {13'b0, busy, fail, pass}. Pass and fail are never both 1, and both are 0 while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |

## Verification
The bench uses the default parameters: 8 pages of 256 halfwords, and latencies of 6, 300 and 21000 cycles. With only 4 KiB of array, the first out-of-range offset (0x1000) is easy to reach, and pages on both sides of an erased page can be checked. A full mass erase, including writes arriving while it is busy, also fits inside the run. The page erase latency is longer than its 256-halfword sweep, while the mass erase sweep is much shorter than its latency, so the latency sets busy in both cases.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam logic [2:0] IDX_STAT = 3'd0;
  localparam logic [2:0] IDX_MODE = 3'd1;
  localparam logic [2:0] IDX_CMD  = 3'd2;
  localparam logic [2:0] IDX_DATA = 3'd3;
  localparam logic [2:0] IDX_ADDR = 3'd4;

  localparam logic [7:0] CODE_READ  = 8'h01;
  localparam logic [7:0] CODE_PROG  = 8'h02;
  localparam logic [7:0] CODE_PAGE  = 8'h05;
  localparam logic [7:0] CODE_MASS  = 8'h06;

  localparam int          WEN_BIT  = 3;
  localparam logic [15:0] KEY_DATA = 16'h3CFF;
  localparam logic [15:0] KEY_ADDR = 16'hFFC3;

  typedef enum logic [1:0] {OP_READ, OP_PROG, OP_PAGE, OP_MASS} op_e;
endpackage

// File: rtl/fcc_array.sv
module fcc_array #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);
  logic [15:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq import fcc_pkg::*; #(
  parameter int DEPTH    = 2048,
  parameter int AW       = 11,
  parameter int PAGE_HW  = 256,
  parameter int PROG_CYC = 6,
  parameter int PAGE_CYC = 300,
  parameter int MASS_CYC = 21000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  op_e           start_op,
  input  logic [AW-1:0] start_hw,
  input  logic [15:0]   start_data,
  input  logic [15:0]   arr_rdata,
  output logic          busy,
  output logic          done,
  output op_e           done_op,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [15:0]   arr_wdata
);
  localparam int LW = $clog2(MASS_CYC + 1);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PAGE_MASK = ~AW'(PAGE_HW - 1);

  logic          busy_q, busy_d;
  op_e           op_q, op_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [LW-1:0] tmr_q, tmr_d;
  logic [CW-1:0] left_q, left_d;
  logic [15:0]   dat_q, dat_d;
  logic          sweep, upd_en;

  always_comb begin
    busy_d = busy_q;
    op_d   = op_q;
    ptr_d  = ptr_q;
    tmr_d  = tmr_q;
    left_d = left_q;
    dat_d  = dat_q;
    done   = 1'b0;
    sweep  = busy_q && (left_q != '0);
    if (busy_q) begin
      tmr_d  = (tmr_q != '0) ? tmr_q - 1'b1 : '0;
      left_d = (left_q != '0) ? left_q - 1'b1 : '0;
      if (sweep) ptr_d = ptr_q + 1'b1;
      done = (tmr_d == '0) && (left_d == '0);
      if (done) busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      op_d   = start_op;
      dat_d  = start_data;
      ptr_d  = start_hw;
      left_d = '0;
      case (start_op)
        OP_READ: tmr_d = LW'(1);
        OP_PROG: tmr_d = LW'(PROG_CYC);
        OP_PAGE: begin
          tmr_d  = LW'(PAGE_CYC);
          left_d = CW'(PAGE_HW);
          ptr_d  = start_hw & PAGE_MASK;
        end
        default: begin
          tmr_d  = LW'(MASS_CYC);
          left_d = CW'(DEPTH);
          ptr_d  = '0;
        end
      endcase
    end
  end

  assign upd_en = busy_q || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_READ;
      ptr_q  <= '0;
      tmr_q  <= '0;
      left_q <= '0;
      dat_q  <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      op_q   <= op_d;
      ptr_q  <= ptr_d;
      tmr_q  <= tmr_d;
      left_q <= left_d;
      dat_q  <= dat_d;
    end
  end

  assign busy      = busy_q;
  assign done_op   = op_q;
  assign arr_addr  = ptr_q;
  assign arr_we    = sweep || (done && op_q == OP_PROG);
  assign arr_wdata = sweep ? 16'hFFFF : (arr_rdata & dat_q);

  // R3: an accepted start raises busy on the following cycle
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q);
  // R3: completion drops busy
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
  // R4: a program write can only clear bits of the stored cell
  a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && !sweep) |-> ((arr_wdata & ~arr_rdata) == 16'h0000));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl import fcc_pkg::*; #(
  parameter int PAGE_HW   = 256,
  parameter int NUM_PAGES = 8,
  parameter int PROG_CYC  = 6,
  parameter int PAGE_CYC  = 300,
  parameter int MASS_CYC  = 21000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata
);
  localparam int DEPTH       = PAGE_HW * NUM_PAGES;
  localparam int AW          = $clog2(DEPTH);
  localparam int ARRAY_BYTES = DEPTH * 2;

  logic        rs1_q, rst_sn;
  logic [15:0] mode_q, mode_d, data_q, data_d, addr_q, addr_d;
  logic        pass_q, pass_d, fail_q, fail_d;
  logic        busy, done, seq_start, wr_ok, in_range, wen, reg_en;
  op_e         done_op, start_op;
  logic        arr_we;
  logic [AW-1:0] arr_addr;
  logic [15:0] arr_wdata, arr_rdata;
  logic [2:0]  idx;
  logic [7:0]  code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q  <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rs1_q  <= 1'b1;
      rst_sn <= rs1_q;
    end
  end

  assign idx      = bus_addr[4:2];
  assign code     = bus_wdata[7:0];
  assign wr_ok    = bus_sel && bus_wr && !busy;
  assign in_range = {16'h0000, addr_q} < 32'(ARRAY_BYTES);
  assign wen      = mode_q[WEN_BIT];

  always_comb begin
    mode_d    = mode_q;
    data_d    = data_q;
    addr_d    = addr_q;
    pass_d    = pass_q;
    fail_d    = fail_q;
    seq_start = 1'b0;
    start_op  = OP_READ;
    if (done) begin
      pass_d = 1'b1;
      if (done_op == OP_READ) data_d = arr_rdata;
    end else if (wr_ok) begin
      case (idx)
        IDX_MODE: mode_d = bus_wdata;
        IDX_DATA: data_d = bus_wdata;
        IDX_ADDR: addr_d = bus_wdata;
        IDX_CMD: begin
          pass_d = 1'b0;
          fail_d = 1'b0;
          case (code)
            CODE_READ: begin
              start_op  = OP_READ;
              seq_start = in_range;
              fail_d    = !in_range;
            end
            CODE_PROG, CODE_PAGE: begin
              start_op  = (code == CODE_PROG) ? OP_PROG : OP_PAGE;
              seq_start = wen && in_range;
              fail_d    = wen && !in_range;
            end
            CODE_MASS: begin
              start_op  = OP_MASS;
              seq_start = wen && (data_q == KEY_DATA) && (addr_q == KEY_ADDR);
              fail_d    = wen && !seq_start;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign reg_en = done || wr_ok;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mode_q <= '0;
      data_q <= '0;
      addr_q <= '0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (reg_en) begin
      mode_q <= mode_d;
      data_q <= data_d;
      addr_q <= addr_d;
      pass_q <= pass_d;
      fail_q <= fail_d;
    end
  end

  always_comb begin
    case (idx)
      IDX_STAT: bus_rdata = {13'b0, busy, fail_q, pass_q};
      IDX_MODE: bus_rdata = mode_q;
      IDX_DATA: bus_rdata = data_q;
      IDX_ADDR: bus_rdata = addr_q;
      default:  bus_rdata = 16'h0000;
    endcase
  end

  fcc_seq #(
    .DEPTH(DEPTH), .AW(AW), .PAGE_HW(PAGE_HW),
    .PROG_CYC(PROG_CYC), .PAGE_CYC(PAGE_CYC), .MASS_CYC(MASS_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_sn), .start(seq_start), .start_op(start_op),
    .start_hw(addr_q[AW:1]), .start_data(data_q), .arr_rdata(arr_rdata),
    .busy(busy), .done(done), .done_op(done_op), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  fcc_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk(clk), .we(arr_we), .addr(arr_addr), .wdata(arr_wdata), .rdata(arr_rdata)
  );

  // R12: pass and fail are exclusive
  a_r12_pass_fail_excl: assert property (@(posedge clk) disable iff (!rst_sn)
    !(pass_q && fail_q));
  // R12: no result is shown while an operation runs
  a_r12_busy_no_result: assert property (@(posedge clk) disable iff (!rst_sn)
    busy |-> (!pass_q && !fail_q));
  // R10: bus writes do not reach the registers while busy
  a_r10_hold_regs: assert property (@(posedge clk) disable iff (!rst_sn)
    busy |=> ($stable(mode_q) && $stable(addr_q)));
  // R7: a modifying operation starts only with writes enabled
  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_sn)
    (seq_start && start_op != OP_READ) |-> mode_q[WEN_BIT]);
  // R8: an addressed operation starts only inside the array
  a_r8_range: assert property (@(posedge clk) disable iff (!rst_sn)
    (seq_start && start_op != OP_MASS) |-> ({16'h0000, addr_q} < 32'(ARRAY_BYTES)));
endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_HW = 256, NUM_PAGES = 8;
  localparam int PROG_CYC = 6, PAGE_CYC = 300, MASS_CYC = 21000;
  localparam int DEPTH = PAGE_HW * NUM_PAGES;
  localparam int BYTES = DEPTH * 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;

  flash_cmd_ctrl #(.PAGE_HW(PAGE_HW), .NUM_PAGES(NUM_PAGES), .PROG_CYC(PROG_CYC),
                   .PAGE_CYC(PAGE_CYC), .MASS_CYC(MASS_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_mem [DEPTH];
  int m_mode, m_data, m_addr, m_pass, m_fail, m_left, m_op, m_hw, m_opd;

  function automatic int max2(int a, int b); return (a > b) ? a : b; endfunction

  function automatic int m_read(int i);
    case (i)
      0: return ((m_left != 0) ? 4 : 0) + (m_fail ? 2 : 0) + (m_pass ? 1 : 0);
      1: return m_mode;
      3: return m_data;
      4: return m_addr;
      default: return 0;
    endcase
  endfunction

  task automatic m_begin(int code, int lat);
    m_pass = 0; m_fail = 0; m_left = lat; m_op = code;
    m_hw = m_addr / 2; m_opd = m_data;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_data = 0; m_addr = 0; m_pass = 0; m_fail = 0; m_left = 0;
    end else if (m_left > 0) begin
      m_left--;
      if (m_left == 0) begin
        m_pass = 1;
        case (m_op)
          1: m_data = m_mem[m_hw];
          2: m_mem[m_hw] = m_mem[m_hw] & m_opd;
          5: for (int k = 0; k < PAGE_HW; k++) m_mem[(m_hw / PAGE_HW) * PAGE_HW + k] = 16'hFFFF;
          default: for (int k = 0; k < DEPTH; k++) m_mem[k] = 16'hFFFF;
        endcase
      end
    end else if (bus_sel && bus_wr) begin
      int code, inr, en;
      code = bus_wdata & 255;
      inr = (m_addr < BYTES);
      en = (m_mode >> 3) & 1;
      case (int'(bus_addr) / 4)
        1: m_mode = bus_wdata;
        3: m_data = bus_wdata;
        4: m_addr = bus_wdata;
        2: begin
          m_pass = 0; m_fail = 0;
          if (code == 1) begin
            if (inr) m_begin(1, 1); else m_fail = 1;
          end else if (code == 2 || code == 5) begin
            if (en && !inr) m_fail = 1;
            else if (en) m_begin(code, (code == 2) ? PROG_CYC : max2(PAGE_CYC, PAGE_HW));
          end else if (code == 6) begin
            if (en && m_data == 16'h3CFF && m_addr == 16'hFFC3) m_begin(6, max2(MASS_CYC, DEPTH));
            else if (en) m_fail = 1;
          end
        end
        default: ;
      endcase
    end
  end

  // compare on every clock
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !bus_wr) begin
      n_cmp++;
      if (int'(bus_rdata) != m_read(int'(bus_addr) / 4)) begin
        n_bad++;
        $display("FAIL %s reg 0x%0h actual 0x%04h expected 0x%04h", cur_req, bus_addr,
                 bus_rdata, m_read(int'(bus_addr) / 4));
      end
    end
    if (cycles > 190000) begin
      n_bad++;
      $display("FAIL watchdog expired during %s actual hung expected finished", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(int off, int val);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'(off); bus_wdata = 16'(val);
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 5'h00;
  endtask

  task automatic look(int off);
    @(negedge clk); #1; bus_addr = 5'(off);
    @(negedge clk); #1; bus_addr = 5'h00;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_left != 0);
    @(negedge clk);
  endtask

  task automatic cmd(int code);
    wr(8, code);
    wait_idle();
  endtask

  task automatic rd_hw(int a);
    wr('h10, a); cmd(1); look('h0C);
  endtask

  task automatic prog(int a, int d);
    wr('h10, a); wr('h0C, d); cmd(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_req = "R1"; look(0); look(4); look('h0C); look('h10);

    cur_req = "R7"; wr('h10, 0); wr('h0C, 0); cmd(2); cmd(5);
    wr('h0C, 'h3CFF); wr('h10, 'hFFC3); cmd(6); look(0);

    cur_req = "R2"; wr(4, 'h0008); look(4); wr('h14, 'hAAAA); look('h14);
    wr('h18, 1); look('h18); wr(8, 'h33); look(8);

    cur_req = "R6"; wr('h10, 'h0000); cmd(6); look(0);
    cur_req = "R3"; wr('h10, 'hFFC3); wr(8, 6);
    cur_req = "R10"; wr(4, 0); wr('h10, 'h0055); wr(8, 5); wr('h0C, 0); look(0);
    wait_idle(); look(4); look('h10); look('h0C);

    cur_req = "R11"; rd_hw(0); rd_hw('h100); rd_hw(BYTES - 2);

    cur_req = "R4"; prog('h10, 'hF0F0); rd_hw('h10); prog('h10, 'h3CC3); rd_hw('h10);
    prog('h21, 'h1234); rd_hw('h20);

    cur_req = "R5"; prog('h1FE, 'h0000); prog('h200, 'h1111); prog('h3FE, 'h2222);
    prog('h400, 'h4444); wr('h10, 'h2FE); cmd(5);
    rd_hw('h1FE); rd_hw('h200); rd_hw('h3FE); rd_hw('h400);

    cur_req = "R8"; wr('h10, BYTES); cmd(2); look(0); cmd(1); look(0); cmd(5); look(0);
    rd_hw(BYTES - 2);

    cur_req = "R9"; wr('h10, 'h10); cmd('h33); look(0); rd_hw('h10);

    cur_req = "R6"; wr('h0C, 'h3CFF); wr('h10, 'hFFC4); cmd(6); look(0); rd_hw('h400);

    cur_req = "R7"; wr(4, 0); prog('h400, 0); look(0); rd_hw('h400);
    wr('h10, 'h400); cmd(5); rd_hw('h400);

    cur_req = "R12"; look(0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule